// File: doc/BRIEF.md
# Constant Divide-by-Three Unit

This block divides an unsigned 32-bit operand by the fixed constant 3 using no divider circuit. A two-bit mode field travels with each operand and picks one of three methods. The default method gives the exact truncated quotient for any 32-bit value. It multiplies by a reciprocal constant and then shifts. A narrow method serves small sums, for example the total of three 8-bit colour channels. It uses a cheap multiply-and-shift that may come out one low. A third method gives an exact quotient only for operands already known to be multiples of 3. It multiplies by the modular inverse of 3 and keeps the low word.

Each operand enters with a valid strobe and passes through two register stages. The first stage holds the full 64-bit product. The second holds the selected and shifted 32-bit result. An out-of-range flag comes out with the result when the narrow method gets an operand larger than it is built for. The output word and the flag keep their last values until a new result arrives.

Top module: `div3_unit`

## Requirements
- R1: While reset (active-low `rst_n`) is held, and right after it, `out_valid`, `out_quot` and `out_range_err` are all 0.
- R2: A result appears with `out_valid` high exactly two rising clock edges after the edge that samples `in_valid` high. Operands may be presented on consecutive cycles, and each produces its own result one cycle after the previous one.
- R3: Modes `2'b00` and `2'b11` give floor(x/3) for every 32-bit operand x. This includes 0, 2, 3 and 0xFFFFFFFF, which gives 0x55555555.
- R4: Mode `2'b01` gives ((x*341) >> 10), truncated to 32 bits. For x from 0 to 768 this never exceeds floor(x/3) and may fall below it. For example, 3 gives 0 and 768 gives 255.
- R5: `out_range_err` is 1 with a result exactly when that result came from mode `2'b01` with an operand above 768. In every other case it is 0.
- R6: Mode `2'b10` gives the low 32 bits of x*0xAAAAAAAB. For any multiple of 3 this equals x/3.
- R7: In mode `2'b10`, an operand that is not a multiple of 3 gives a wrapped value r with (3*r) mod 2^32 = x. For example, 11 gives 0x55555559.
- R8: While no result is arriving, `out_quot` and `out_range_err` keep the values of the last result, whatever `in_data` and `in_mode` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_mode | input | 2 | Method select: 00/11 exact truncating, 01 small range, 10 exact multiple |
| in_data | input | 32 | Unsigned dividend |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| out_quot | output | 32 | Quotient produced by the selected method |
| out_range_err | output | 1 | Small-range operand was above 768 |

## Verification
The bench checks the top of the operand range, 0xFFFFFFFF. A reciprocal shift that is off by one bit would return about half or twice 0x55555555 there. It checks the small-range edges 3 and 768, where a design that rounded the small path, or swapped in the exact path, would return the true quotient instead of the lower one. It checks the non-multiple 11 in exact-multiple mode, which exposes a truncating fallback or a mis-sliced product word. It also checks the flag at 768 and 769, the held output during idle cycles, and back-to-back operands that would collide if the stage enables were wrong.

// File: rtl/div3_pkg.sv
package div3_pkg;

    // Method select carried alongside every operand
    typedef enum logic [1:0] {
        MODE_TRUNC     = 2'b00,
        MODE_SMALL     = 2'b01,
        MODE_MULT      = 2'b10,
        MODE_TRUNC_ALT = 2'b11
    } div3_mode_e;

endpackage

// File: rtl/div3_product_stage.sv
module div3_product_stage
    import div3_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          PROD_W      = 2 * DATA_W,
    parameter logic [31:0] RECIP       = 32'hAAAA_AAAB,
    parameter int          SMALL_MUL   = 341,
    parameter int          SMALL_LIMIT = 768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  div3_mode_e        in_mode,
    input  logic [DATA_W-1:0] in_data,
    output logic              s1_valid,
    output div3_mode_e        s1_mode,
    output logic [PROD_W-1:0] s1_prod,
    output logic              s1_oor
);

    localparam logic [PROD_W-1:0] K_RECIP = PROD_W'(RECIP);
    localparam logic [PROD_W-1:0] K_SMALL = PROD_W'(SMALL_MUL);
    localparam logic [DATA_W-1:0] LIMIT_V = DATA_W'(SMALL_LIMIT);

    logic [PROD_W-1:0] mul_k;
    logic [PROD_W-1:0] prod;
    logic              oor_now;

    always_comb begin
        unique case (in_mode)
            MODE_SMALL: mul_k = K_SMALL;
            MODE_TRUNC, MODE_MULT, MODE_TRUNC_ALT: mul_k = K_RECIP;
            default:    mul_k = K_RECIP;
        endcase
        prod    = PROD_W'(in_data) * mul_k;
        oor_now = (in_mode == MODE_SMALL) && (in_data > LIMIT_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_mode  <= MODE_TRUNC;
            s1_prod  <= '0;
            s1_oor   <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_mode <= in_mode;
                s1_prod <= prod;
                s1_oor  <= oor_now;
            end
        end
    end

    // R5: only the small-range method may raise the range flag
    assert_flag_small_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode != MODE_SMALL) |=> !s1_oor);

endmodule

// File: rtl/div3_select_stage.sv
module div3_select_stage
    import div3_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int PROD_W      = 2 * DATA_W,
    parameter int TRUNC_SH    = 33,
    parameter int SMALL_SH    = 10,
    parameter int SMALL_LIMIT = 768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  div3_mode_e        s1_mode,
    input  logic [PROD_W-1:0] s1_prod,
    input  logic              s1_oor,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_quot,
    output logic              out_range_err
);

    localparam int                PAD       = TRUNC_SH + DATA_W - PROD_W;
    localparam logic [DATA_W-1:0] MAX_Q     = {DATA_W{1'b1}} / 3;
    localparam logic [DATA_W-1:0] SMALL_MAX = DATA_W'(SMALL_LIMIT / 3);

    logic [DATA_W-1:0] q_trunc;
    logic [DATA_W-1:0] q_small;
    logic [DATA_W-1:0] q_mult;
    logic [DATA_W-1:0] q_sel;

    always_comb begin
        q_trunc = {{PAD{1'b0}}, s1_prod[PROD_W-1:TRUNC_SH]};
        q_small = s1_prod[SMALL_SH +: DATA_W];
        q_mult  = s1_prod[DATA_W-1:0];
        unique case (s1_mode)
            MODE_SMALL:                 q_sel = q_small;
            MODE_MULT:                  q_sel = q_mult;
            MODE_TRUNC, MODE_TRUNC_ALT: q_sel = q_trunc;
            default:                    q_sel = q_trunc;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_quot      <= '0;
            out_range_err <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_quot      <= q_sel;
                out_range_err <= s1_oor;
            end
        end
    end

    // R3: a truncating quotient can never exceed the quotient of the largest operand
    assert_trunc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && (s1_mode == MODE_TRUNC || s1_mode == MODE_TRUNC_ALT))
            |=> (out_quot <= MAX_Q));

    // R4: an in-range small operand gives at most limit/3
    assert_small_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_mode == MODE_SMALL && !s1_oor) |=> (out_quot <= SMALL_MAX));

endmodule

// File: rtl/div3_unit.sv
module div3_unit
    import div3_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter logic [31:0] RECIP       = 32'hAAAA_AAAB,
    parameter int          TRUNC_SH    = 33,
    parameter int          SMALL_MUL   = 341,
    parameter int          SMALL_SH    = 10,
    parameter int          SMALL_LIMIT = 768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_mode,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_quot,
    output logic              out_range_err
);

    localparam int PROD_W = 2 * DATA_W;

    div3_mode_e        s1_mode;
    logic              s1_valid;
    logic [PROD_W-1:0] s1_prod;
    logic              s1_oor;

    div3_product_stage #(
        .DATA_W(DATA_W), .PROD_W(PROD_W), .RECIP(RECIP),
        .SMALL_MUL(SMALL_MUL), .SMALL_LIMIT(SMALL_LIMIT)
    ) u_product (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_mode(div3_mode_e'(in_mode)), .in_data(in_data),
        .s1_valid(s1_valid), .s1_mode(s1_mode), .s1_prod(s1_prod), .s1_oor(s1_oor)
    );

    div3_select_stage #(
        .DATA_W(DATA_W), .PROD_W(PROD_W), .TRUNC_SH(TRUNC_SH),
        .SMALL_SH(SMALL_SH), .SMALL_LIMIT(SMALL_LIMIT)
    ) u_select (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_mode(s1_mode),
        .s1_prod(s1_prod), .s1_oor(s1_oor),
        .out_valid(out_valid), .out_quot(out_quot), .out_range_err(out_range_err)
    );

    // R2: every accepted operand yields a result two edges later
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R2: no result appears without an operand two edges earlier
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R8: outputs hold while no result arrives
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_quot) && $stable(out_range_err)));

endmodule

// File: tb/div3_unit_bench.sv
`timescale 1ns/1ps
module div3_unit_bench;

    localparam logic [31:0] INV3 = 32'hAAAA_AAAB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_mode = 2'b00;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [31:0] out_quot;
    logic        out_range_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    div3_unit u_div3_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_data(in_data), .out_valid(out_valid), .out_quot(out_quot),
        .out_range_err(out_range_err)
    );

    // Stimulus table: {mode, operand}
    localparam logic [33:0] VEC [16] = '{
        {2'b00, 32'd0},          {2'b00, 32'd2},        {2'b00, 32'd3},
        {2'b00, 32'hFFFF_FFFF},  {2'b11, 32'd1000},     {2'b00, 32'hFFFF_FFFD},
        {2'b01, 32'd0},          {2'b01, 32'd3},        {2'b01, 32'd765},
        {2'b01, 32'd768},        {2'b01, 32'd769},      {2'b01, 32'd5000},
        {2'b10, 32'd0},          {2'b10, 32'd300},      {2'b10, 32'hFFFF_FFFF},
        {2'b10, 32'd11}
    };

    function automatic logic [31:0] ref_quot(input logic [1:0] m, input logic [31:0] x);
        logic [63:0] w;
        case (m)
            2'b01:   begin w = (64'(x) * 64'd341) >> 10; return w[31:0]; end
            2'b10:   begin w = 64'(x) * 64'(INV3);       return w[31:0]; end
            default: return x / 32'd3;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'b01:   return "R4";
            2'b10:   return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [1:0] m, input logic [31:0] x,
                           input logic [31:0] exp, input logic exp_err, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; in_data = x;
        @(negedge clk);
        in_valid = 1'b0; in_data = $urandom; in_mode = 2'($urandom);
        chk("R2 early", 32'(out_valid), 32'd0);
        @(negedge clk);
        chk("R2 valid", 32'(out_valid), 32'd1);
        chk(req, out_quot, exp);
        chk("R5 flag", 32'(out_range_err), 32'(exp_err));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", 32'(out_valid), 32'd0);
        chk("R1 quot", out_quot, 32'd0);
        chk("R1 flag", 32'(out_range_err), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'(out_valid), 32'd0);

        // Table walk
        for (int i = 0; i < 16; i++) begin
            logic [1:0]  m;
            logic [31:0] x;
            m = VEC[i][33:32];
            x = VEC[i][31:0];
            run_one(m, x, ref_quot(m, x), (m == 2'b01) && (x > 32'd768),
                    (m == 2'b10 && (x % 3) != 0) ? "R7" : tag_of(m));
        end

        // Directed corner values written out
        run_one(2'b00, 32'hFFFF_FFFF, 32'h5555_5555, 1'b0, "R3 max");
        run_one(2'b00, 32'd2, 32'd0, 1'b0, "R3 two");
        run_one(2'b11, 32'd3, 32'd1, 1'b0, "R3 alt three");
        run_one(2'b01, 32'd3, 32'd0, 1'b0, "R4 three low");
        run_one(2'b01, 32'd768, 32'd255, 1'b0, "R4 limit");
        run_one(2'b01, 32'd769, 32'd256, 1'b1, "R5 above limit");
        run_one(2'b10, 32'd999, 32'd333, 1'b0, "R6 multiple");
        run_one(2'b10, 32'd11, 32'h5555_5559, 1'b0, "R7 eleven");
        chk("R7 times three", out_quot * 32'd3, 32'd11);

        // R4: in-range small results never exceed the true quotient
        for (int x = 0; x <= 768; x += 97) begin
            run_one(2'b01, 32'(x), ref_quot(2'b01, 32'(x)), 1'b0, "R4 sweep");
            n_checks++;
            if (out_quot > 32'(x / 3)) begin
                n_fail++;
                $display("FAIL R4 bound: actual %h expected <= %h", out_quot, 32'(x / 3));
            end
        end

        // R3: random operands against integer division
        for (int k = 0; k < 40; k++) begin
            logic [31:0] x;
            x = $urandom;
            run_one(2'b00, x, x / 32'd3, 1'b0, "R3 random");
        end

        // R8: hold while idle, inputs wiggling
        run_one(2'b01, 32'd900, ref_quot(2'b01, 32'd900), 1'b1, "R5 hold setup");
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            in_data = $urandom; in_mode = 2'($urandom);
            chk("R8 idle valid", 32'(out_valid), 32'd0);
            chk("R8 quot held", out_quot, ref_quot(2'b01, 32'd900));
            chk("R8 flag held", 32'(out_range_err), 32'd1);
        end

        // R2: back-to-back operands
        @(negedge clk);
        in_valid = 1'b1; in_mode = 2'b00; in_data = 32'd30;
        @(negedge clk);
        in_mode = 2'b10; in_data = 32'd33;
        @(negedge clk);
        in_mode = 2'b01; in_data = 32'd800;
        chk("R2 b2b first valid", 32'(out_valid), 32'd1);
        chk("R3 b2b first", out_quot, 32'd10);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 b2b second valid", 32'(out_valid), 32'd1);
        chk("R6 b2b second", out_quot, 32'd11);
        chk("R5 b2b second flag", 32'(out_range_err), 32'd0);
        @(negedge clk);
        chk("R2 b2b third valid", 32'(out_valid), 32'd1);
        chk("R4 b2b third", out_quot, ref_quot(2'b01, 32'd800));
        chk("R5 b2b third flag", 32'(out_range_err), 32'd1);
        @(negedge clk);
        chk("R2 b2b drain", 32'(out_valid), 32'd0);

        // R1: reset mid-run clears the outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset quot", out_quot, 32'd0);
        chk("R1 re-reset flag", 32'(out_range_err), 32'd0);

        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule